// File: doc/BRIEF.md
# Transparent Serial Frame Link

This block moves unformatted frames over a single data line in each direction. A frame carries no flags and no sync word. The transmitter marks a frame by holding its active-low request-to-send output low, and the receiver sees a frame while its active-low carrier-detect input is low.

The transmit side takes bytes from a valid/ready stream. Each byte carries a last marker, and the first byte of a frame also carries a CRC-enable flag. The transmitter starts whenever data is offered and never waits for a clear-to-send. It shifts bits out on one bit-clock enable. The receive side samples its line on a separate bit-clock enable. It returns whole bytes, then a single end-of-frame pulse with abort and CRC status.

The two directions share only the clock and reset. Their frame timing is independent. A link between two peers is made by wiring each request-to-send to the other side's carrier-detect.

Top module: `tfl_link`

## Requirements
- R1: After reset, tx_rts_no and tx_line_o are high, tx_underrun_o is low, and rx_valid_o, rx_eof_o, rx_abort_o and rx_crc_err_o are low.
- R2: tx_rts_no falls on the same tx_bit_en_i edge that puts the first data bit on tx_line_o. Bytes go out MSB first, and each bit is held for one bit-enable period. tx_rts_no changes only on a bit-enable edge.
- R3: tx_ready_o is high only together with tx_bit_en_i, when the transmitter is idle or has just finished a byte that was not marked last. No clear-to-send input is consulted.
- R4: For a frame of n bytes, tx_rts_no stays low for exactly 8n bit periods, or 8n+16 with CRC enabled. It then rises, and tx_line_o idles high whenever tx_rts_no is high.
- R5: When tx_crc_en_i is high with the first byte, 16 CRC bits follow the last data bit. The CRC uses polynomial 0x1021 with preset 0xFFFF, is computed over the data bits MSB first, and is sent inverted, MSB first. With the flag low, no CRC is sent.
- R6: If tx_valid_i is low at a byte boundary inside a frame, the frame ends on that bit-enable edge. tx_rts_no rises, no CRC is sent, and tx_underrun_o pulses for one cycle.
- R7: On each rx_bit_en_i edge with rx_cd_ni low, the receiver samples rx_line_i. The first such sample is frame data. Every 8 samples give one byte on rx_data_o (first sample in bit 7) with a one-cycle rx_valid_o. CRC bits are delivered as data.
- R8: The first rx_bit_en_i edge with rx_cd_ni high after a frame gives a one-cycle rx_eof_o. rx_abort_o is set with it when the sample count is not a multiple of 8. The partial byte is dropped and never shown on rx_valid_o.
- R9: rx_crc_err_o pulses with rx_eof_o only when rx_crc_chk_i is high and the frame was not aborted. It is set when the frame is shorter than 16 bits, or when its last 16 bits are not the inverted R5 CRC of the bits before them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_bit_en_i | input | 1 | Transmit bit-clock enable |
| tx_data_i | input | DATA_W | Byte to send |
| tx_last_i | input | 1 | Byte closes the frame |
| tx_crc_en_i | input | 1 | Append CRC (read with the first byte) |
| tx_valid_i | input | 1 | Byte offered |
| tx_ready_o | output | 1 | Byte taken this cycle when valid |
| tx_line_o | output | 1 | Serial transmit data |
| tx_rts_no | output | 1 | Request-to-send, active low |
| tx_underrun_o | output | 1 | Frame cut short by missing data |
| rx_bit_en_i | input | 1 | Receive bit-clock enable |
| rx_line_i | input | 1 | Serial receive data |
| rx_cd_ni | input | 1 | Carrier detect, active low |
| rx_crc_chk_i | input | 1 | Check CRC at frame end |
| rx_data_o | output | DATA_W | Received byte |
| rx_valid_o | output | 1 | rx_data_o holds a new byte |
| rx_eof_o | output | 1 | Frame ended |
| rx_abort_o | output | 1 | Frame ended inside a byte |
| rx_crc_err_o | output | 1 | CRC check failed |

## Verification
The bench loops the transmitter back into the receiver and sweeps frame lengths of one to six bytes, with and without CRC. In each frame it measures how long tx_rts_no stays low and compares every returned byte against CRC arithmetic computed in the bench. A design that raises RTS one bit early or late would show a wrong low time and a lost or extra bit. A design that forgets to invert the CRC, or sends it LSB first, would fail the byte comparison and raise a CRC error.

A single flipped line bit must raise rx_crc_err_o, and must not raise it when checking is off. An underrun must end the frame with no CRC and one underrun pulse. Carrier-detect driven directly by the bench tests frames that stop after 3 bits, after 12 bits, and on an exact 16-bit boundary. A receiver that leaked a partial byte, or flagged abort on a whole-byte frame, would be caught there.

// File: rtl/tfl_pkg.sv
package tfl_pkg;
  localparam int unsigned CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_INIT = 16'hFFFF;

  typedef enum logic [1:0] {TX_IDLE, TX_DATA, TX_CRC} tx_st_e;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
    crc_step = {c[CRC_W-2:0], 1'b0} ^ ((c[CRC_W-1] ^ b) ? CRC_POLY : '0);
  endfunction

  // register value left after an inverted CRC has been shifted in
  function automatic logic [CRC_W-1:0] crc_residue();
    logic [CRC_W-1:0] c;
    c = '0;
    for (int i = 0; i < CRC_W; i++) c = crc_step(c, 1'b1);
    return c;
  endfunction
endpackage

// File: rtl/tfl_tx.sv
module tfl_tx
  import tfl_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              last_i,
  input  logic              crc_en_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              line_o,
  output logic              rts_no,
  output logic              underrun_o
);
  localparam int unsigned CNT_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int unsigned CCNT_W = $clog2(CRC_W);
  localparam logic [CNT_W-1:0]  CNT_TOP  = CNT_W'(DATA_W - 1);
  localparam logic [CCNT_W-1:0] CCNT_TOP = CCNT_W'(CRC_W - 1);

  tx_st_e             state_q;
  logic [DATA_W-1:0]  sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CCNT_W-1:0]  ccnt_q;
  logic [CRC_W-1:0]   crc_q;
  logic               crc_en_q, last_q, rts_n_q, line_q, ur_q;
  logic               idle, at_boundary, load;
  logic [CRC_W-1:0]   crc_base;

  assign idle        = (state_q == TX_IDLE);
  assign at_boundary = (state_q == TX_DATA) && (cnt_q == '0) && !last_q;
  assign ready_o     = bit_en_i && (idle || at_boundary);
  assign load        = ready_o && valid_i;
  assign crc_base    = idle ? CRC_INIT : crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= TX_IDLE;
      sh_q     <= '0;
      cnt_q    <= '0;
      ccnt_q   <= '0;
      crc_q    <= CRC_INIT;
      crc_en_q <= 1'b0;
      last_q   <= 1'b0;
      rts_n_q  <= 1'b1;
      line_q   <= 1'b1;
      ur_q     <= 1'b0;
    end else begin
      ur_q <= 1'b0;
      if (load) begin
        state_q <= TX_DATA;
        line_q  <= data_i[DATA_W-1];
        sh_q    <= {data_i[DATA_W-2:0], 1'b0};
        cnt_q   <= CNT_TOP;
        last_q  <= last_i;
        rts_n_q <= 1'b0;
        crc_q   <= crc_step(crc_base, data_i[DATA_W-1]);
        if (idle) crc_en_q <= crc_en_i;
      end else if (bit_en_i) begin
        unique case (state_q)
          TX_DATA: begin
            if (cnt_q != '0) begin
              line_q <= sh_q[DATA_W-1];
              sh_q   <= {sh_q[DATA_W-2:0], 1'b0};
              cnt_q  <= cnt_q - 1'b1;
              crc_q  <= crc_step(crc_q, sh_q[DATA_W-1]);
            end else if (last_q && crc_en_q) begin
              state_q <= TX_CRC;
              line_q  <= ~crc_q[CRC_W-1];
              crc_q   <= {crc_q[CRC_W-2:0], 1'b0};
              ccnt_q  <= CCNT_TOP;
            end else begin
              // last byte done without CRC, or no data at a boundary
              state_q <= TX_IDLE;
              rts_n_q <= 1'b1;
              line_q  <= 1'b1;
              ur_q    <= !last_q;
            end
          end
          TX_CRC: begin
            if (ccnt_q != '0) begin
              line_q <= ~crc_q[CRC_W-1];
              crc_q  <= {crc_q[CRC_W-2:0], 1'b0};
              ccnt_q <= ccnt_q - 1'b1;
            end else begin
              state_q <= TX_IDLE;
              rts_n_q <= 1'b1;
              line_q  <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign line_o     = line_q;
  assign rts_no     = rts_n_q;
  assign underrun_o = ur_q;

  a_r4_line_idles_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rts_no |-> line_o);
  a_r2_rts_moves_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rts_no) |-> $past(bit_en_i));
  a_r6_underrun_drops_rts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |-> rts_no && $past(!rts_no));
  a_r5_crc_only_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TX_CRC) |-> last_q && crc_en_q && !rts_no);
endmodule

// File: rtl/tfl_rx.sv
module tfl_rx
  import tfl_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              line_i,
  input  logic              cd_ni,
  input  logic              crc_chk_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              eof_o,
  output logic              abort_o,
  output logic              crc_err_o
);
  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(DATA_W - 1);
  localparam logic [CRC_W-1:0] RESIDUE  = crc_residue();
  // bytes needed before the frame can hold a whole CRC
  localparam int unsigned MIN_BYTES = (CRC_W + DATA_W - 1) / DATA_W;
  localparam int unsigned NB_W      = $clog2(MIN_BYTES + 1);

  logic              in_frame_q;
  logic [DATA_W-1:0] sh_q, byte_q;
  logic [CNT_W-1:0]  bcnt_q;
  logic [NB_W-1:0]   nb_q;
  logic [CRC_W-1:0]  crc_q;
  logic              vld_q, eof_q, abort_q, err_q;
  logic              byte_done, long_enough;

  assign byte_done   = (bcnt_q == CNT_TOP);
  assign long_enough = (nb_q >= NB_W'(MIN_BYTES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      sh_q       <= '0;
      byte_q     <= '0;
      bcnt_q     <= '0;
      nb_q       <= '0;
      crc_q      <= CRC_INIT;
      vld_q      <= 1'b0;
      eof_q      <= 1'b0;
      abort_q    <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      vld_q   <= 1'b0;
      eof_q   <= 1'b0;
      abort_q <= 1'b0;
      err_q   <= 1'b0;
      if (bit_en_i) begin
        if (!cd_ni) begin
          in_frame_q <= 1'b1;
          sh_q       <= {sh_q[DATA_W-2:0], line_i};
          crc_q      <= crc_step(crc_q, line_i);
          bcnt_q     <= byte_done ? '0 : bcnt_q + 1'b1;
          if (byte_done) begin
            byte_q <= {sh_q[DATA_W-2:0], line_i};
            vld_q  <= 1'b1;
            if (!long_enough) nb_q <= nb_q + 1'b1;
          end
        end else if (in_frame_q) begin
          in_frame_q <= 1'b0;
          eof_q      <= 1'b1;
          abort_q    <= (bcnt_q != '0);
          err_q      <= crc_chk_i && (bcnt_q == '0) && (!long_enough || crc_q != RESIDUE);
          bcnt_q     <= '0;
          nb_q       <= '0;
          crc_q      <= CRC_INIT;
        end
      end
    end
  end

  assign data_o    = byte_q;
  assign valid_o   = vld_q;
  assign eof_o     = eof_q;
  assign abort_o   = abort_q;
  assign crc_err_o = err_q;

  a_r7_byte_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(bit_en_i) && $past(!cd_ni));
  a_r8_abort_with_eof: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> eof_o);
  a_r9_err_needs_whole_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_err_o |-> eof_o && !abort_o);
  a_r8_eof_after_cd_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |-> $past(cd_ni) && !valid_o);
endmodule

// File: rtl/tfl_link.sv
module tfl_link #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_bit_en_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_last_i,
  input  logic              tx_crc_en_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              tx_line_o,
  output logic              tx_rts_no,
  output logic              tx_underrun_o,
  input  logic              rx_bit_en_i,
  input  logic              rx_line_i,
  input  logic              rx_cd_ni,
  input  logic              rx_crc_chk_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              rx_eof_o,
  output logic              rx_abort_o,
  output logic              rx_crc_err_o
);
  tfl_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_en_i   (tx_bit_en_i),
    .data_i     (tx_data_i),
    .last_i     (tx_last_i),
    .crc_en_i   (tx_crc_en_i),
    .valid_i    (tx_valid_i),
    .ready_o    (tx_ready_o),
    .line_o     (tx_line_o),
    .rts_no     (tx_rts_no),
    .underrun_o (tx_underrun_o)
  );

  tfl_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_en_i  (rx_bit_en_i),
    .line_i    (rx_line_i),
    .cd_ni     (rx_cd_ni),
    .crc_chk_i (rx_crc_chk_i),
    .data_o    (rx_data_o),
    .valid_o   (rx_valid_o),
    .eof_o     (rx_eof_o),
    .abort_o   (rx_abort_o),
    .crc_err_o (rx_crc_err_o)
  );
endmodule

// File: tb/tfl_link_tb.sv
module tfl_link_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       bit_en = 1'b0;
  logic [1:0] div = '0;
  always @(posedge clk) begin
    div    <= div + 1'b1;
    bit_en <= (div == 2'd3);
  end

  logic [7:0] tx_data = '0;
  logic tx_last = 0, tx_crc_en = 0, tx_valid = 0;
  logic tx_ready, tx_line, tx_rts_n, tx_ur;
  logic loop = 1, flip = 0, man_cd_n = 1, man_line = 1, chk = 1;
  logic rx_line, rx_cd_n;
  logic [7:0] rx_data;
  logic rx_valid, rx_eof, rx_abort, rx_err;

  assign rx_line = loop ? (tx_line ^ flip) : man_line;
  assign rx_cd_n = loop ? tx_rts_n : man_cd_n;

  tfl_link #(.DATA_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_bit_en_i(bit_en), .tx_data_i(tx_data), .tx_last_i(tx_last),
    .tx_crc_en_i(tx_crc_en), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .tx_line_o(tx_line), .tx_rts_no(tx_rts_n), .tx_underrun_o(tx_ur),
    .rx_bit_en_i(bit_en), .rx_line_i(rx_line), .rx_cd_ni(rx_cd_n),
    .rx_crc_chk_i(chk), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .rx_eof_o(rx_eof), .rx_abort_o(rx_abort), .rx_crc_err_o(rx_err)
  );

  int total = 0, bad = 0;
  int eof_cnt = 0, ur_cnt = 0, rts_cyc = 0, ready_bad = 0;
  logic last_abort = 0, last_err = 0;
  logic [7:0] rx_q[$];
  logic [7:0] exp_q[$];

  always @(negedge clk) begin
    if (rx_valid) rx_q.push_back(rx_data);
    if (rx_eof) begin eof_cnt++; last_abort = rx_abort; last_err = rx_err; end
    if (tx_ur) ur_cnt++;
    if (!tx_rts_n) rts_cyc++;
    if (tx_ready && !bit_en) ready_bad++;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_of(input logic [7:0] q[$], input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++)
      for (int b = 7; b >= 0; b--) begin
        logic fb = c[15] ^ q[i][b];
        c = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h1021;
      end
    return c;
  endfunction

  function automatic logic exp_err(input logic [7:0] q[$]);
    int n = q.size();
    if (n < 2) return 1'b1;
    return {q[n-2], q[n-1]} != ~crc_of(q, n - 2);
  endfunction

  task automatic clear_stats();
    repeat (12) @(negedge clk);
    eof_cnt = 0; ur_cnt = 0; rts_cyc = 0;
    rx_q.delete(); exp_q.delete();
  endtask

  task automatic wait_eof();
    for (int i = 0; i < 3000 && eof_cnt == 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input int n, input logic crc, input logic underrun);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx_data   = 8'((n * 37 + i * 53 + 8'h5A) ^ (crc ? 8'hC3 : 8'h00));
      tx_last   = !underrun && (i == n - 1);
      tx_crc_en = crc;
      tx_valid  = 1'b1;
      exp_q.push_back(tx_data);
      while (!tx_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    tx_valid = 1'b0; tx_last = 1'b0;
  endtask

  task automatic run_frame(input int n, input logic crc, input logic c_chk,
                           input logic underrun, input logic corrupt);
    logic [15:0] c;
    int bits;
    clear_stats();
    loop = 1; chk = c_chk;
    fork
      send(n, crc, underrun);
      begin
        if (corrupt) begin
          wait (!tx_rts_n);
          repeat (41) @(negedge clk);
          flip = 1'b1;
          repeat (4) @(negedge clk);
          flip = 1'b0;
        end
      end
    join
    wait_eof();
    if (crc && !underrun) begin
      c = ~crc_of(exp_q, n);
      exp_q.push_back(c[15:8]);
      exp_q.push_back(c[7:0]);
    end
    bits = 8 * exp_q.size();
    check("R4 rts low time", rts_cyc, bits * 4);
    check("R8 one eof", eof_cnt, 1);
    check("R8 no abort", last_abort, 0);
    check("R6 underrun pulses", ur_cnt, underrun ? 1 : 0);
    check("R7 byte count", rx_q.size(), exp_q.size());
    if (!corrupt && rx_q.size() == exp_q.size())
      for (int i = 0; i < exp_q.size(); i++)
        check("R2 R5 R7 byte value", rx_q[i], exp_q[i]);
    check("R9 crc status", last_err, c_chk && (corrupt ? 1'b1 : exp_err(exp_q)));
  endtask

  task automatic man_frame(input int nbits, input logic [23:0] pat,
                           input int exp_bytes, input logic exp_ab);
    clear_stats();
    loop = 0; chk = 1;
    for (int k = 0; k < nbits; k++) begin
      @(negedge clk);
      while (!bit_en) @(negedge clk);
      man_cd_n = 1'b0;
      man_line = pat[23 - k];
    end
    @(negedge clk);
    while (!bit_en) @(negedge clk);
    man_cd_n = 1'b1; man_line = 1'b1;
    wait_eof();
    check("R8 manual eof", eof_cnt, 1);
    check("R8 abort flag", last_abort, exp_ab);
    check("R8 partial byte dropped", rx_q.size(), exp_bytes);
    for (int i = 0; i < exp_bytes && i < rx_q.size(); i++)
      check("R7 manual byte", rx_q[i], pat[23 - 8*i -: 8]);
    if (exp_ab) check("R9 no crc err on abort", last_err, 0);
    else begin
      for (int i = 0; i < exp_bytes; i++) exp_q.push_back(pat[23 - 8*i -: 8]);
      check("R9 manual crc status", last_err, exp_err(exp_q));
    end
    loop = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] g;
    logic [7:0] two_q[$];
    repeat (3) @(negedge clk);
    check("R1 rts idle", tx_rts_n, 1);
    check("R1 line idle", tx_line, 1);
    check("R1 rx quiet", {rx_valid, rx_eof, rx_abort, rx_err, tx_ur}, 0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    check("R1 after release", {tx_rts_n, tx_line, rx_valid, rx_eof}, 4'b1100);

    for (int n = 1; n <= 6; n++)
      for (int c = 0; c < 2; c++) run_frame(n, c[0], 1'b1, 1'b0, 1'b0);
    run_frame(3, 1'b0, 1'b0, 1'b0, 1'b0);  // R9 check disabled
    run_frame(3, 1'b1, 1'b1, 1'b1, 1'b0);  // R6 underrun, no CRC appended
    run_frame(4, 1'b1, 1'b1, 1'b0, 1'b1);  // R9 flipped bit detected
    run_frame(4, 1'b1, 1'b0, 1'b0, 1'b1);  // R9 flipped bit, checking off
    check("R3 ready only on bit enable", ready_bad, 0);

    man_frame(12, 24'hA5_C0_00, 1, 1'b1);
    man_frame(3, 24'hE0_00_00, 0, 1'b0 | 1'b1);
    two_q.push_back(8'h12);
    g = ~crc_of(two_q, 1);
    man_frame(24, {8'h12, g}, 3, 1'b0);   // R9 valid CRC on exact boundary
    man_frame(16, 24'h3C_96_00, 2, 1'b0);
    run_frame(2, 1'b1, 1'b1, 1'b0, 1'b0); // clean frame after aborts

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule